// File: doc/BRIEF.md
# Reorder Buffer Vulnerability Throttle

This block sits beside a reorder buffer and keeps a running, cycle-exact count of the bits in that buffer that would corrupt architectural state if a particle strike flipped them. An entry contributes its dispatch-time payload (B bits) from the moment it is allocated. Once its result has been written back, it also contributes the R-bit result field. All of these bits leave the count when the entry commits or is squashed. The block holds back instruction dispatch whenever admitting one more instruction could push the count past a programmable ceiling. This bounds the buffer's exposure in every cycle, not just on average.

The block owns the ring pointers of the buffer. Dispatch always allocates the entry at the tail, and that index is shown on `disp_idx`. Commit always retires the head. Writebacks arrive on `WB_PORTS` independent ports, each carrying an entry index, and they are never refused. Only dispatch is throttled. Dispatch is a valid/ready stream: an instruction transfers on a cycle where `disp_valid` and `disp_ready` are both high. While `disp_ready` is low, the producer must hold its instruction, and nothing is allocated. Commit, squash, writeback and the ceiling write are plain control pins and take effect in the cycle they are presented.

Top module: `rob_vuln_throttle`

## Requirements
- R1: After reset the count is 0, no entry is allocated, `disp_idx` is 0, `disp_stall` is low and `disp_ready` is high. The ceiling resets to N*(B+R).
- R2: A dispatch transfer allocates the entry at `disp_idx` and adds B to the count on the next cycle. `disp_idx` then advances by one, modulo N (from N-1 back to 0).
- R3: A writeback to an allocated entry whose result is unwritten adds R once, even if several ports name that entry in the same cycle. A writeback to an unallocated entry, or to one already written, leaves the count unchanged.
- R4: Writebacks are accepted while `disp_stall` is high. The count still grows by R per accepted entry.
- R5: A commit while the head entry is allocated and written releases B+R and advances the head by one, modulo N. A commit while the head is unwritten or the buffer is empty changes nothing.
- R6: A squash naming an allocated entry removes that entry and every younger one. It releases B for each removed entry and R for each removed written entry, and moves `disp_idx` to the squashed index. In that cycle, `disp_ready` is low, a commit is ignored, and writebacks to removed entries are ignored. A squash naming an unallocated entry has no effect.
- R7: `disp_stall` is high exactly when count + B + R*WB_PORTS exceeds the ceiling, or when all N entries are allocated. `disp_ready` equals `!disp_stall && !squash_valid`.
- R8: A ceiling write replaces the ceiling. The stall decision in the cycle of the write still uses the old value; the next cycle uses the new one.
- R9: The count always equals B times the allocated entries plus R times the written entries. It never drops below 0 and never exceeds N*(B+R).
- R10: With all N entries allocated, dispatch is refused even if the count is far below the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_ready | output | 1 | Dispatch is accepted this cycle |
| disp_idx | output | IDX_W | Entry index the next dispatch allocates (tail) |
| wb_valid | input | WB_PORTS | Per-port writeback strobe |
| wb_idx | input | WB_PORTS*IDX_W | Per-port writeback entry index, port p at bits [p*IDX_W +: IDX_W] |
| commit_valid | input | 1 | Request to retire the head entry |
| squash_valid | input | 1 | Squash request |
| squash_idx | input | IDX_W | Oldest entry to remove on a squash |
| bound_wr_en | input | 1 | Ceiling write strobe |
| bound_wr_data | input | CNT_W | New ceiling value |
| disp_stall | output | 1 | Dispatch held back by the ceiling or by a full buffer |
| vuln_count | output | CNT_W | Current vulnerable-bit count |

## Verification
Several properties are checked on every cycle. The running count must match the tally rebuilt from the per-entry allocated and written flags, and it must stay inside its range without underflowing. The count one cycle after any accepted dispatch must not exceed the ceiling that admitted it. A full buffer must never show ready, a writeback landing during a stall must mark its entry written, and commit must step the head by exactly one. The bench's scenarios cover the rest:
- duplicate and stray writebacks;
- commits refused on an unwritten head;
- a squash overlapping writebacks and a commit;
- a squash that names an empty slot;
- tail wrap-around;
- the one-cycle delay of a new ceiling.

// File: rtl/rvt_pkg.sv
package rvt_pkg;

  // Age of a ring slot relative to the oldest slot: 0 for the oldest entry.
  function automatic int unsigned ring_age(int unsigned slot, int unsigned base,
                                           int unsigned depth);
    return (slot + depth - base) % depth;
  endfunction

endpackage

// File: rtl/rvt_entry_table.sv
module rvt_entry_table
  import rvt_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int WB_PORTS  = 2,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int OCC_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         disp_fire_i,
  input  logic [WB_PORTS-1:0]          wb_valid_i,
  input  logic [WB_PORTS*IDX_W-1:0]    wb_idx_i,
  input  logic                         commit_valid_i,
  input  logic                         squash_valid_i,
  input  logic [IDX_W-1:0]             squash_idx_i,
  output logic [IDX_W-1:0]             head_o,
  output logic [IDX_W-1:0]             tail_o,
  output logic                         full_o,
  output logic [N_ENTRIES-1:0]         alloc_o,
  output logic [N_ENTRIES-1:0]         written_o,
  output logic [N_ENTRIES-1:0]         wb_hit_o,
  output logic [N_ENTRIES-1:0]         sq_mask_o,
  output logic                         commit_fire_o
);

  logic [N_ENTRIES-1:0] alloc_q, written_q;
  logic [IDX_W-1:0]     head_q, tail_q;
  logic [OCC_W-1:0]     occ_q;

  logic                 sq_active;
  int unsigned          sq_age;
  logic [N_ENTRIES-1:0] port_match;
  logic [N_ENTRIES-1:0] head_onehot, tail_onehot;
  logic [IDX_W-1:0]     head_inc, tail_inc;

  // Any writeback port naming slot e.
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_match
    always_comb begin
      port_match[e] = 1'b0;
      for (int p = 0; p < WB_PORTS; p++) begin
        if (wb_valid_i[p] && (wb_idx_i[p*IDX_W +: IDX_W] == IDX_W'(e)))
          port_match[e] = 1'b1;
      end
    end
    assign head_onehot[e] = (head_q == IDX_W'(e));
    assign tail_onehot[e] = (tail_q == IDX_W'(e));
  end

  always_comb begin
    sq_active = squash_valid_i && alloc_q[squash_idx_i];
    sq_age    = ring_age(int'(squash_idx_i), int'(head_q), N_ENTRIES);
    for (int e = 0; e < N_ENTRIES; e++) begin
      sq_mask_o[e] = sq_active && alloc_q[e] &&
                     (ring_age(e, int'(head_q), N_ENTRIES) >= sq_age);
      wb_hit_o[e]  = port_match[e] && alloc_q[e] && !written_q[e] && !sq_mask_o[e];
    end
    commit_fire_o = commit_valid_i && !sq_active && alloc_q[head_q] && written_q[head_q];
    head_inc = (head_q == IDX_W'(N_ENTRIES - 1)) ? '0 : head_q + 1'b1;
    tail_inc = (tail_q == IDX_W'(N_ENTRIES - 1)) ? '0 : tail_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_q   <= '0;
      written_q <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      occ_q     <= '0;
    end else begin
      alloc_q   <= (alloc_q & ~sq_mask_o & ~(commit_fire_o ? head_onehot : '0))
                 | (disp_fire_i ? tail_onehot : '0);
      written_q <= (written_q | wb_hit_o) & ~sq_mask_o & ~(commit_fire_o ? head_onehot : '0);
      if (commit_fire_o) head_q <= head_inc;
      if (sq_active) begin
        tail_q <= squash_idx_i;
        occ_q  <= occ_q - OCC_W'($countones(sq_mask_o));
      end else begin
        if (disp_fire_i) tail_q <= tail_inc;
        occ_q <= occ_q + OCC_W'(disp_fire_i) - OCC_W'(commit_fire_o);
      end
    end
  end

  assign head_o    = head_q;
  assign tail_o    = tail_q;
  assign full_o    = (occ_q == OCC_W'(N_ENTRIES));
  assign alloc_o   = alloc_q;
  assign written_o = written_q;

endmodule

// File: rtl/rvt_vuln_counter.sv
module rvt_vuln_counter #(
  parameter int N_ENTRIES = 8,
  parameter int B_BITS    = 10,
  parameter int R_BITS    = 16,
  localparam int MAX_CNT  = N_ENTRIES * (B_BITS + R_BITS),
  localparam int CNT_W    = $clog2(MAX_CNT + 1),
  localparam int OCC_W    = $clog2(N_ENTRIES + 1),
  localparam int SUM_W    = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_fire_i,
  input  logic [OCC_W-1:0] n_wb_i,
  input  logic             commit_fire_i,
  input  logic [OCC_W-1:0] n_sq_alloc_i,
  input  logic [OCC_W-1:0] n_sq_written_i,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o
);

  localparam logic [SUM_W-1:0] B_C   = SUM_W'(B_BITS);
  localparam logic [SUM_W-1:0] R_C   = SUM_W'(R_BITS);
  localparam logic [SUM_W-1:0] MAX_C = SUM_W'(MAX_CNT);

  logic [CNT_W-1:0] count_q, count_d;
  logic [SUM_W-1:0] gain, loss, total, diff;

  always_comb begin
    gain  = (disp_fire_i ? B_C : '0) + SUM_W'(n_wb_i) * R_C;
    loss  = (commit_fire_i ? (B_C + R_C) : '0)
          + SUM_W'(n_sq_alloc_i) * B_C + SUM_W'(n_sq_written_i) * R_C;
    total = {2'b00, count_q} + gain;
    underflow_o = (loss > total);
    diff  = total - loss;
    if (underflow_o)        count_d = '0;
    else if (diff > MAX_C)  count_d = MAX_C[CNT_W-1:0];
    else                    count_d = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

endmodule

// File: rtl/rvt_stall_gate.sv
module rvt_stall_gate #(
  parameter int N_ENTRIES = 8,
  parameter int B_BITS    = 10,
  parameter int R_BITS    = 16,
  parameter int WB_PORTS  = 2,
  localparam int MAX_CNT  = N_ENTRIES * (B_BITS + R_BITS),
  localparam int CNT_W    = $clog2(MAX_CNT + 1),
  localparam int SUM_W    = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             full_i,
  input  logic             bound_wr_en_i,
  input  logic [CNT_W-1:0] bound_wr_data_i,
  output logic             stall_o,
  output logic [CNT_W-1:0] bound_o
);

  // Worst-case growth if one more instruction enters and every port writes back.
  localparam logic [SUM_W-1:0] HEADROOM = SUM_W'(B_BITS + R_BITS * WB_PORTS);

  logic [CNT_W-1:0] bound_q;
  logic [SUM_W-1:0] projected;

  always_ff @(posedge clk) begin
    if (!rst_n)             bound_q <= CNT_W'(MAX_CNT);
    else if (bound_wr_en_i) bound_q <= bound_wr_data_i;
  end

  assign projected = {2'b00, count_i} + HEADROOM;
  assign stall_o   = full_i || (projected > {2'b00, bound_q});
  assign bound_o   = bound_q;

endmodule

// File: rtl/rob_vuln_throttle.sv
module rob_vuln_throttle #(
  parameter int N_ENTRIES = 8,
  parameter int B_BITS    = 10,
  parameter int R_BITS    = 16,
  parameter int WB_PORTS  = 2,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int OCC_W    = $clog2(N_ENTRIES + 1),
  localparam int CNT_W    = $clog2(N_ENTRIES * (B_BITS + R_BITS) + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_valid,
  output logic                      disp_ready,
  output logic [IDX_W-1:0]          disp_idx,
  input  logic [WB_PORTS-1:0]       wb_valid,
  input  logic [WB_PORTS*IDX_W-1:0] wb_idx,
  input  logic                      commit_valid,
  input  logic                      squash_valid,
  input  logic [IDX_W-1:0]          squash_idx,
  input  logic                      bound_wr_en,
  input  logic [CNT_W-1:0]          bound_wr_data,
  output logic                      disp_stall,
  output logic [CNT_W-1:0]          vuln_count
);

  logic                 disp_fire, full, commit_fire, underflow;
  logic [IDX_W-1:0]     head, tail;
  logic [N_ENTRIES-1:0] alloc, written, wb_hit, sq_mask;
  logic [CNT_W-1:0]     bound_q;
  logic [OCC_W-1:0]     n_wb, n_sq_alloc, n_sq_written;

  assign disp_ready = !disp_stall && !squash_valid;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_idx   = tail;

  assign n_wb         = OCC_W'($countones(wb_hit));
  assign n_sq_alloc   = OCC_W'($countones(sq_mask));
  assign n_sq_written = OCC_W'($countones(sq_mask & written));

  rvt_entry_table #(.N_ENTRIES(N_ENTRIES), .WB_PORTS(WB_PORTS)) u_table (
    .clk(clk), .rst_n(rst_n), .disp_fire_i(disp_fire),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .commit_valid_i(commit_valid),
    .squash_valid_i(squash_valid), .squash_idx_i(squash_idx),
    .head_o(head), .tail_o(tail), .full_o(full), .alloc_o(alloc),
    .written_o(written), .wb_hit_o(wb_hit), .sq_mask_o(sq_mask),
    .commit_fire_o(commit_fire)
  );

  rvt_vuln_counter #(.N_ENTRIES(N_ENTRIES), .B_BITS(B_BITS), .R_BITS(R_BITS)) u_count (
    .clk(clk), .rst_n(rst_n), .disp_fire_i(disp_fire), .n_wb_i(n_wb),
    .commit_fire_i(commit_fire), .n_sq_alloc_i(n_sq_alloc),
    .n_sq_written_i(n_sq_written), .count_o(vuln_count), .underflow_o(underflow)
  );

  rvt_stall_gate #(.N_ENTRIES(N_ENTRIES), .B_BITS(B_BITS), .R_BITS(R_BITS),
                   .WB_PORTS(WB_PORTS)) u_gate (
    .clk(clk), .rst_n(rst_n), .count_i(vuln_count), .full_i(full),
    .bound_wr_en_i(bound_wr_en), .bound_wr_data_i(bound_wr_data),
    .stall_o(disp_stall), .bound_o(bound_q)
  );

endmodule

// File: rtl/rvt_checker.sv
module rvt_checker #(
  parameter int N_ENTRIES = 8,
  parameter int B_BITS    = 10,
  parameter int R_BITS    = 16,
  parameter int WB_PORTS  = 2,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int MAX_CNT  = N_ENTRIES * (B_BITS + R_BITS),
  localparam int CNT_W    = $clog2(MAX_CNT + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      disp_fire,
  input logic                      disp_ready,
  input logic                      full,
  input logic                      commit_fire,
  input logic                      underflow,
  input logic                      squash_valid,
  input logic [CNT_W-1:0]          vuln_count,
  input logic [CNT_W-1:0]          bound_q,
  input logic [IDX_W-1:0]          head,
  input logic [N_ENTRIES-1:0]      alloc,
  input logic [N_ENTRIES-1:0]      written,
  input logic [WB_PORTS-1:0]       wb_valid,
  input logic [WB_PORTS*IDX_W-1:0] wb_idx
);

  logic [IDX_W-1:0] wb0;
  assign wb0 = wb_idx[IDX_W-1:0];

  assert_count_tracks_entries_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vuln_count) == B_BITS * $countones(alloc) + R_BITS * $countones(written));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !underflow);

  assert_count_capped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vuln_count) <= MAX_CNT);

  assert_dispatch_within_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> int'(vuln_count) <= int'($past(bound_q)));

  assert_full_refuses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready);

  assert_wb_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid[0] && !squash_valid && alloc[wb0] && !written[wb0]) |=> written[$past(wb0)]);

  assert_commit_steps_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> int'(head) == (int'($past(head)) + 1) % N_ENTRIES);

endmodule

bind rob_vuln_throttle rvt_checker #(
  .N_ENTRIES(N_ENTRIES), .B_BITS(B_BITS), .R_BITS(R_BITS), .WB_PORTS(WB_PORTS)
) u_rvt_checker (
  .clk(clk), .rst_n(rst_n), .disp_fire(disp_fire), .disp_ready(disp_ready),
  .full(full), .commit_fire(commit_fire), .underflow(underflow),
  .squash_valid(squash_valid), .vuln_count(vuln_count), .bound_q(bound_q),
  .head(head), .alloc(alloc), .written(written), .wb_valid(wb_valid), .wb_idx(wb_idx)
);

// File: tb/tb_rob_vuln_throttle.sv
module tb_rob_vuln_throttle;

  localparam int N = 8;
  localparam int B = 10;
  localparam int R = 16;
  localparam int P = 2;
  localparam int IDX_W = 3;
  localparam int MAXC = N * (B + R);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, commit_valid = 1'b0, squash_valid = 1'b0, bound_wr_en = 1'b0;
  logic [P-1:0] wb_valid = '0;
  logic [P*IDX_W-1:0] wb_idx = '0;
  logic [IDX_W-1:0] squash_idx = '0;
  logic [CNT_W-1:0] bound_wr_data = '0;
  logic disp_ready, disp_stall;
  logic [IDX_W-1:0] disp_idx;
  logic [CNT_W-1:0] vuln_count;

  always #4 clk = ~clk;

  rob_vuln_throttle #(.N_ENTRIES(N), .B_BITS(B), .R_BITS(R), .WB_PORTS(P)) dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_idx(disp_idx), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .commit_valid(commit_valid), .squash_valid(squash_valid), .squash_idx(squash_idx),
    .bound_wr_en(bound_wr_en), .bound_wr_data(bound_wr_data),
    .disp_stall(disp_stall), .vuln_count(vuln_count)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  // Reference model state
  bit m_alloc[N], m_wr[N];
  int m_head = 0, m_tail = 0, m_occ = 0, m_cnt = 0, m_bound = MAXC;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks comb outputs, queues expected count.
  task automatic cyc(input bit d, input bit w0v, input int w0i, input bit w1v, input int w1i,
                     input bit c, input bit sv, input int si, input bit bw, input int bd,
                     input string tag);
    bit exp_stall, exp_ready, sq_act, cfire, dfire;
    bit rm[N], hit[N];
    int sq_age, removed;
    disp_valid = d; wb_valid = {w1v, w0v};
    wb_idx = {IDX_W'(w1i), IDX_W'(w0i)};
    commit_valid = c; squash_valid = sv; squash_idx = IDX_W'(si);
    bound_wr_en = bw; bound_wr_data = CNT_W'(bd);
    #1;
    exp_stall = (m_occ == N) || (m_cnt + B + R * P > m_bound);
    exp_ready = !exp_stall && !sv;
    chk(disp_stall == exp_stall, {tag, " R7 stall"}, int'(disp_stall), int'(exp_stall));
    chk(disp_ready == exp_ready, {tag, " R7 ready"}, int'(disp_ready), int'(exp_ready));
    chk(int'(disp_idx) == m_tail, {tag, " R2 idx"}, int'(disp_idx), m_tail);
    sq_act = sv && m_alloc[si];
    sq_age = (si - m_head + N) % N;
    removed = 0;
    for (int i = 0; i < N; i++) begin
      rm[i] = sq_act && m_alloc[i] && (((i - m_head + N) % N) >= sq_age);
      hit[i] = m_alloc[i] && !m_wr[i] && !rm[i] && ((w0v && w0i == i) || (w1v && w1i == i));
    end
    cfire = c && !sq_act && m_alloc[m_head] && m_wr[m_head];
    dfire = d && exp_ready;
    for (int i = 0; i < N; i++) begin
      if (rm[i]) begin
        m_cnt -= B + (m_wr[i] ? R : 0);
        m_alloc[i] = 0; m_wr[i] = 0; removed++;
      end
      if (hit[i]) begin m_cnt += R; m_wr[i] = 1; end
    end
    if (cfire) begin
      m_cnt -= B + R; m_alloc[m_head] = 0; m_wr[m_head] = 0;
      m_head = (m_head + 1) % N; m_occ--;
    end
    if (sq_act) begin
      m_tail = si; m_occ -= removed;
    end else if (dfire) begin
      m_cnt += B; m_alloc[m_tail] = 1; m_tail = (m_tail + 1) % N; m_occ++;
    end
    if (bw) m_bound = bd;
    exp_q.push_back(m_cnt); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compares the count after each edge against the queued expectation.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(int'(vuln_count) == e, {t, " count"}, int'(vuln_count), e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(vuln_count == 0, "R1 count", int'(vuln_count), 0);
    chk(disp_ready == 1'b1, "R1 ready", int'(disp_ready), 1);
    chk(disp_stall == 1'b0, "R1 stall", int'(disp_stall), 0);
    chk(disp_idx == 0, "R1 idx", int'(disp_idx), 0);
    @(negedge clk);
    // R2: three dispatches
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3: both ports on the same entry, then stray and repeated writebacks
    cyc(0, 1, 1, 1, 1, 0, 0, 0, 0, 0, "R3");
    cyc(0, 1, 5, 1, 1, 0, 0, 0, 0, 0, "R3");
    // R5: commit of unwritten head is ignored, then real commits
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
    // R8: ceiling write with dispatch in the same cycle still uses the old ceiling
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 1, 40, "R8");
    // R4: stalled, writebacks still land
    cyc(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 0, 1, 3, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, MAXC, "R8");
    // R2 wrap and R10 full
    for (int k = 0; k < 6; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // R6: squash from slot 6 with writebacks to a removed and a surviving entry
    cyc(1, 1, 7, 1, 4, 1, 1, 6, 0, 0, "R6");
    // R6: squash naming an empty slot is ignored, commit goes ahead
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
    // R6: squash everything from the head
    cyc(0, 1, 5, 0, 0, 0, 1, 5, 0, 0, "R6");
    idle("R9");
    // R7: tight ceiling under writeback pressure
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 60, "R8");
    for (int k = 0; k < 4; k++) cyc(1, 1, (m_tail + N - 1) % N, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
    idle("R9");
    idle("R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule